// File: doc/BRIEF.md
# Third-order sinc decimator with selectable ratio

This block turns a one-bit delta-sigma modulator stream into signed 16-bit samples. It runs on the master clock. A clock-enable marks each modulator sample, one in every eight master cycles in normal use. Each enabled bit counts as +1 (bit high) or -1 (bit low). The bits pass through a third-order cascaded integrator-comb filter with response ((1 - z^-N)/(1 - z^-1))^3, where N is the decimation ratio.

A rate-select pin picks the ratio. Low selects 256 and high selects 128, so at one sample per eight clocks the output rate is clock/2048 or clock/1024. The full-precision result is shifted right to 16 bits and clamped: full positive scale gives 0x7FFF, full negative scale gives 0x8000, and a zero-mean stream gives 0x0000.

A new setting of the pin is taken only at an output boundary. Each output carries a flag that is low while the filter history is incomplete. One instance serves one channel.

Top module: `sinc3_decim`

## Requirements
- R1: With rate-select low, exactly 256 enabled modulator samples separate two consecutive output strobes.
- R2: With rate-select high, exactly 128 enabled modulator samples separate two consecutive output strobes.
- R3: A stream of all-ones bits produces 0x7FFF once settled, at either ratio, because the positive full-scale value is clamped.
- R4: A stream of all-zero bits produces 0x8000 once settled, at either ratio.
- R5: A stream of alternating ones and zeros produces 0x0000 once settled, at either ratio.
- R6: A repeating four-bit pattern with three ones and one zero produces 0x4000 (+16384) once settled. The pattern with one one and three zeros produces 0xC000 (-16384).
- R7: A change of rate-select takes effect at the next output boundary. The output in progress when the pin changes still completes at the old ratio.
- R8: The settled flag is low on the first three outputs after reset and high on the fourth. The three outputs that follow a boundary at which the ratio changed also carry a low flag.
- R9: While reset is asserted (rst_ni low), valid_o, settled_o and sample_o are all 0.
- R10: Cycles with the clock-enable low do not advance the filter or the sample count, and no output strobe appears while the enable is held low.
- R11: valid_o is high for one clock cycle per output.
- R12: sample_o holds its value between output strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Modulator sample enable |
| mod_bit_i | input | 1 | Modulator bit; 1 counts as +1, 0 as -1 |
| rate_sel_i | input | 1 | 0: ratio 256, 1: ratio 128 |
| sample_o | output | 16 | Two's-complement output sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |
| settled_o | output | 1 | High when the sample's filter history is complete; meaningful with valid_o |

## Verification
The assertions check the properties that hold on every cycle:
- the strobe spacing is always either of the two ratios,
- each strobe is a single cycle and follows an enabled sample,
- the sample holds between strobes,
- the settled flag stays low on the first outputs after reset.

The output values themselves can only be shown by the bench scenarios. These drive steady bit patterns whose settled results are known in closed form and compare the outputs against them. The scenarios also cover:
- the exact boundary at which a ratio change applies,
- the low settled flags that follow a ratio change,
- a long enable pause that must neither advance the counter nor disturb the result.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} rate_e;

  // integrator width: order*log2(ratio) growth, one sign bit, one bit for +full scale
  function automatic int acc_bits(input int order, input int log2_max);
    return order * log2_max + 2;
  endfunction

  function automatic int trim_shift(input int order, input int log2_r, input int out_w);
    return order * log2_r - (out_w - 1);
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] step;
  assign step = bit_i ? ACC_W'(1) : '1;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [ACC_W-1:0] q;
    logic [ACC_W-1:0] feed;
    if (g == 0) begin : g_head
      assign feed = step;
    end else begin : g_tail
      assign feed = g_stage[g-1].q;
    end
    // wrap-around sum; comb differences undo the overflow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= '0;
      else if (en_i) q <= q + feed;
    end
  end

  assign acc_o = g_stage[ORDER-1].q;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] diff_o
);
  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [ACC_W-1:0] dly_q;
    logic [ACC_W-1:0] din;
    logic [ACC_W-1:0] dout;
    if (g == 0) begin : g_head
      assign din = acc_i;
    end else begin : g_tail
      assign din = g_stage[g-1].dout;
    end
    assign dout = din - dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dly_q <= '0;
      else if (strobe_i) dly_q <= din;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       diff_o <= '0;
    else if (strobe_i) diff_o <= g_stage[ORDER-1].dout;
  end
endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int SLOW_LOG2 = 8,
  parameter int FAST_LOG2 = 7,
  parameter int SETTLE_N  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rate_sel_i,
  output logic strobe_o,
  output logic valid_o,
  output logic settled_o,
  output logic out_fast_o
);
  localparam int CNT_W  = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam int LEFT_W = $clog2(SETTLE_N + 1);
  localparam logic [CNT_W-1:0]  LAST_SLOW = CNT_W'((1 << SLOW_LOG2) - 1);
  localparam logic [CNT_W-1:0]  LAST_FAST = CNT_W'((1 << FAST_LOG2) - 1);
  localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(SETTLE_N);

  rate_e             cur_q, req;
  logic [CNT_W-1:0]  cnt_q, last;
  logic [LEFT_W-1:0] left_q;

  assign req      = rate_e'(rate_sel_i);
  assign last     = (cur_q == RATE_FAST) ? LAST_FAST : LAST_SLOW;
  assign strobe_o = en_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cur_q      <= RATE_SLOW;
      left_q     <= LEFT_INIT;
      valid_o    <= 1'b0;
      settled_o  <= 1'b0;
      out_fast_o <= 1'b0;
    end else begin
      valid_o <= strobe_o;
      if (en_i) cnt_q <= strobe_o ? '0 : cnt_q + 1'b1;
      if (strobe_o) begin
        settled_o  <= (left_q == '0);
        out_fast_o <= (cur_q == RATE_FAST);
        cur_q      <= req;
        if (req != cur_q)     left_q <= LEFT_INIT;
        else if (left_q != 0) left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
  parameter int ACC_W    = 26,
  parameter int OUT_W    = 16,
  parameter int SLOW_SH  = 9,
  parameter int FAST_SH  = 6
) (
  input  logic signed [ACC_W-1:0] full_i,
  input  logic                    fast_i,
  output logic [OUT_W-1:0]        sample_o
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO = ~HI;

  logic signed [ACC_W-1:0] shifted;
  assign shifted = fast_i ? (full_i >>> FAST_SH) : (full_i >>> SLOW_SH);

  always_comb begin
    if (shifted > HI)      sample_o = HI[OUT_W-1:0];
    else if (shifted < LO) sample_o = LO[OUT_W-1:0];
    else                   sample_o = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int ORDER     = 3,
  parameter int OUT_W     = 16,
  parameter int SLOW_LOG2 = 8,
  parameter int FAST_LOG2 = 7,
  parameter int SETTLE_N  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_en_i,
  input  logic             mod_bit_i,
  input  logic             rate_sel_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o,
  output logic             settled_o
);
  localparam int ACC_W   = acc_bits(ORDER, SLOW_LOG2);
  localparam int SLOW_SH = trim_shift(ORDER, SLOW_LOG2, OUT_W);
  localparam int FAST_SH = trim_shift(ORDER, FAST_LOG2, OUT_W);

  logic             strobe, out_fast;
  logic [ACC_W-1:0] acc, diff;

  sinc3_ctrl #(
    .SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2), .SETTLE_N(SETTLE_N)
  ) u_ctrl (
    .clk_i, .rst_ni, .en_i(mod_en_i), .rate_sel_i,
    .strobe_o(strobe), .valid_o, .settled_o, .out_fast_o(out_fast)
  );

  sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk_i, .rst_ni, .en_i(mod_en_i), .bit_i(mod_bit_i), .acc_o(acc)
  );

  sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk_i, .rst_ni, .strobe_i(strobe), .acc_i(acc), .diff_o(diff)
  );

  sinc3_scale #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .SLOW_SH(SLOW_SH), .FAST_SH(FAST_SH)
  ) u_scale (
    .full_i($signed(diff)), .fast_i(out_fast), .sample_o
  );
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int OUT_W     = 16,
  parameter int SLOW_LOG2 = 8,
  parameter int FAST_LOG2 = 7,
  parameter int SETTLE_N  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mod_en_i,
  input logic [OUT_W-1:0] sample_o,
  input logic             valid_o,
  input logic             settled_o
);
  localparam logic [15:0] GAP_SLOW = 16'(1 << SLOW_LOG2);
  localparam logic [15:0] GAP_FAST = 16'(1 << FAST_LOG2);

  logic [15:0] gap_q;
  logic        seen_q;
  logic [7:0]  nval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      nval_q <= '0;
    end else if (valid_o) begin
      gap_q  <= mod_en_i ? 16'd1 : 16'd0;
      seen_q <= 1'b1;
      if (nval_q != 8'hff) nval_q <= nval_q + 1'b1;
    end else begin
      gap_q <= gap_q + {15'd0, mod_en_i};
    end
  end

  // R1 R2
  period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> (gap_q == GAP_SLOW || gap_q == GAP_FAST));

  // R11
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R10
  gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(mod_en_i));

  // R8
  early_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && nval_q < 8'(SETTLE_N)) |-> !settled_o);

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!valid_o && !settled_o && sample_o == '0);
    end
  end
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .OUT_W(OUT_W), .SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2), .SETTLE_N(SETTLE_N)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mod_en_i(mod_en_i),
  .sample_o(sample_o), .valid_o(valid_o), .settled_o(settled_o)
);

// File: tb/tb_sinc3_decim.sv
module tb_sinc3_decim;
  typedef struct {
    bit          chk_val;
    logic [15:0] val;
    bit          settled;
    int          gap;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic        mod_bit = 1'b0;
  logic        rate_sel = 1'b0;
  logic [15:0] sample;
  logic        valid, settled;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   mode = 0, idx = 0, div = 0, en_cnt = 0, valids_seen = 0;
  bit   en_on = 1'b0, prev_valid = 1'b0, finished = 1'b0;

  always #4 clk = ~clk;

  sinc3_decim dut (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .mod_bit_i(mod_bit),
    .rate_sel_i(rate_sel), .sample_o(sample), .valid_o(valid), .settled_o(settled)
  );

  function automatic logic pat(input int m, input int i);
    case (m)
      0: return 1'b1;
      1: return 1'b0;
      2: return i[0];
      3: return (i % 4) != 0;
      default: return (i % 4) == 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit cv, input logic [15:0] v, input bit st,
                      input int gap, input string req);
    exp_t e;
    e.chk_val = cv; e.val = v; e.settled = st; e.gap = gap; e.req = req;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic settle_and_check(input int m, input logic [15:0] v,
                                  input int gap, input string req);
    drain();
    mode = m;
    for (int k = 0; k < 4; k++) push(1'b0, 16'h0, 1'b1, gap, req);
    for (int k = 0; k < 2; k++) push(1'b1, v, 1'b1, gap, req);
    drain();
  endtask

  // monitor then driver, one place per negedge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid) begin
        valids_seen++;
        check(!prev_valid, "R11", "strobe width", 2, 1);
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected output", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.gap != 0) check(en_cnt == e.gap, e.req, "gap", en_cnt, e.gap);
          if (e.chk_val)
            check(sample == e.val, e.req, "sample", int'($signed(sample)), int'($signed(e.val)));
          check(settled == e.settled, e.req, "settled", int'(settled), int'(e.settled));
        end
        en_cnt = 0;
      end
      prev_valid = rst_n && valid;
      if (en_on) begin
        div = (div + 1) % 8;
        if (div == 0) begin
          mod_en  = 1'b1;
          mod_bit = pat(mode, idx);
          idx++;
          en_cnt++;
        end else begin
          mod_en = 1'b0;
        end
      end else begin
        mod_en = 1'b0;
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    int vs;
    repeat (5) @(negedge clk);
    // R9 reset state
    check(valid == 1'b0, "R9", "valid in reset", int'(valid), 0);
    check(settled == 1'b0, "R9", "settled in reset", int'(settled), 0);
    check(sample == 16'h0, "R9", "sample in reset", int'(sample), 0);
    mode = 0;
    rst_n = 1'b1;
    en_on = 1'b1;

    // R8 first three outputs unsettled; R1 spacing; R3 clamp
    push(1'b0, 16'h0, 1'b0, 0, "R8");
    push(1'b0, 16'h0, 1'b0, 256, "R8");
    push(1'b0, 16'h0, 1'b0, 256, "R8");
    push(1'b1, 16'h7fff, 1'b1, 256, "R1 R3");
    push(1'b1, 16'h7fff, 1'b1, 256, "R1 R3");
    drain();

    settle_and_check(1, 16'h8000, 256, "R4");
    settle_and_check(2, 16'h0000, 256, "R5");
    settle_and_check(3, 16'h4000, 256, "R6");
    settle_and_check(4, 16'hc000, 256, "R6");

    // R7 ratio switch applies at the next boundary
    rate_sel = 1'b1;
    push(1'b0, 16'h0, 1'b1, 256, "R7");
    push(1'b0, 16'h0, 1'b0, 128, "R8");
    push(1'b0, 16'h0, 1'b0, 128, "R8");
    push(1'b0, 16'h0, 1'b0, 128, "R8");
    push(1'b1, 16'hc000, 1'b1, 128, "R2 R6");
    push(1'b1, 16'hc000, 1'b1, 128, "R2 R6");
    drain();

    settle_and_check(0, 16'h7fff, 128, "R2 R3");
    settle_and_check(1, 16'h8000, 128, "R2 R4");
    settle_and_check(2, 16'h0000, 128, "R2 R5");

    // R10 enable pause; R12 hold
    held = sample;
    vs = valids_seen;
    en_on = 1'b0;
    repeat (3000) @(negedge clk);
    check(valids_seen == vs, "R10", "strobes during pause", valids_seen - vs, 0);
    check(sample == held, "R12", "held sample", int'(sample), int'(held));
    en_on = 1'b1;
    push(1'b1, 16'h0000, 1'b1, 128, "R10");
    push(1'b1, 16'h0000, 1'b1, 128, "R10");
    drain();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule